// File: doc/BRIEF.md
# Serial Controller Byte FIFOs with Threshold Interrupts

This block sits between a register port and the bus engine of a serial controller. It holds two byte queues. The transmit queue is filled by register writes and drained by the bus engine. The receive queue is filled by the bus engine and drained by register reads. A control word sets a trigger level for each direction:

- The transmit side flags almost-empty once its fill drops to its trigger or below, so software can refill it in one burst.
- The receive side flags almost-full once its fill reaches its trigger, so software can drain it in one burst.
- A small idle timer (the trailing timer) covers the tail of a receive burst that never reaches the trigger. It flags the leftover bytes once no new byte has arrived for a programmed number of cycles.

Overruns and underruns on either queue are recorded as sticky events. All events collect in an interrupt status word. Software clears that word by writing ones to it. The interrupt output is the OR of the status bits that the enable mask allows. The receive and transmit enables, and all registers, are reachable through a single word-indexed read/write port. Register reads are combinational.

The trailing timer is a three-state machine:

- **IDLE**: no leftover data is being timed.
- **COUNT**: the idle cycles are being counted.
- **FIRED**: the event has been raised for this batch.

Its transitions are:

- IDLE→COUNT on a received byte, or when the receive queue holds fewer bytes than its trigger and is not empty (armed).
- COUNT→COUNT with the count reset to zero on a received byte.
- COUNT→IDLE when no longer armed.
- COUNT→FIRED when armed and the count has reached the programmed limit. The event is raised on this transition.
- FIRED→COUNT on a received byte.
- FIRED→IDLE when no longer armed.

Top module: `serial_fifo_irq`

## Requirements
- R1: After reset, the control word, the interrupt enable word and the interrupt status word are all zero. The trailing limit reads 0xF. The status word reads 0x01000100, meaning both queues are empty with level zero.
- R2: The status word (index 1) has the following layout:
  - TX level in bits 6:0, TX full at bit 7, TX empty at bit 8.
  - RX level in bits 22:16, RX full at bit 23, RX empty at bit 24.
  - All other bits read zero.
- R3: The control word (index 0) has RX enable at bit 0, TX enable at bit 1, the RX trigger in bits 10:4 and the TX trigger in bits 22:16. Bytes written to TX data (index 4) while TX is enabled appear on `tx_data` in write order. `tx_valid` is high exactly when TX is enabled and its queue is non-empty. `tx_take` removes the head byte.
- R4: Bytes presented with `rx_valid` while RX is enabled are returned, in arrival order, by reads of RX data (index 5). Each read with `reg_rd` removes one byte.
- R5: Interrupt status bit 0 (TX almost-empty) is set on each cycle in which TX is enabled and the TX level is at or below the TX trigger.
- R6: Interrupt status bit 1 (RX almost-full) is set on each cycle in which RX is enabled and the RX level is non-zero and at or above the RX trigger.
- R7: A TX data write to a full TX queue discards the byte and sets bit 3 (TX overrun). A `tx_take` on an empty, enabled TX queue sets bit 2 (TX underrun).
- R8: A received byte arriving at a full RX queue is discarded and sets bit 5 (RX overrun). An RX data read on an empty queue returns zero and sets bit 4 (RX underrun).
- R9: Writing the interrupt status word (index 3) clears exactly the bits written as one. An event arriving in the same cycle keeps its bit set.
- R10: `irq` is high exactly when some interrupt status bit is set whose bit is also set in the enable word (index 2, bits 6:0).
- R11: The trailing timer limit is held in index 6, bits 3:0. While the RX queue is armed, bit 6 (trailing) is set on the (limit+1)-th clock edge after the last received byte.
- R12: While TX is disabled, TX data writes and `tx_take` have no effect. While RX is disabled, bytes from the bus are dropped. No overrun or underrun is recorded in either case.
- R13: Each received byte restarts the trailing count. The trailing event never fires while the RX queue is empty or its level is at or above the RX trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX data at index 5) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | TX head byte available to the bus engine |
| tx_data | output | 8 | TX head byte |
| tx_take | input | 1 | Bus engine consumes the TX head byte |
| rx_valid | input | 1 | Bus engine delivers a received byte |
| rx_data | input | 8 | Received byte |

## Verification
The bench builds the block with a queue depth of 16. At that depth, filling each queue to full, and one byte past full, takes only a handful of writes, so both overrun paths, the full flags and the discard of the extra byte are all exercised. The trailing limit is reprogrammed to 3, which keeps the restart and firing cases a few cycles long. The triggers of 2 (TX) and 4 (RX) leave room on both sides of each threshold comparison.

// File: rtl/sfifo_pkg.sv
`timescale 1ns/1ps
package sfifo_pkg;
    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_STAT = 3'd1,
        REG_IEN  = 3'd2,
        REG_IST  = 3'd3,
        REG_TXD  = 3'd4,
        REG_RXD  = 3'd5,
        REG_TRL  = 3'd6,
        REG_RSV  = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        TR_IDLE  = 2'd0,
        TR_COUNT = 2'd1,
        TR_FIRED = 2'd2
    } trail_state_e;

    localparam int NUM_EV    = 7;
    localparam int EV_TX_AE  = 0;
    localparam int EV_RX_AF  = 1;
    localparam int EV_TX_UND = 2;
    localparam int EV_TX_OVR = 3;
    localparam int EV_RX_UND = 4;
    localparam int EV_RX_OVR = 5;
    localparam int EV_TRAIL  = 6;

    localparam int LVL_FIELD = 7;
    localparam int TRL_W     = 4;
    localparam logic [TRL_W-1:0] TRL_RESET = 4'hF;
endpackage

// File: rtl/byte_fifo.sv
`timescale 1ns/1ps
module byte_fifo #(
    parameter int DEPTH = 16,
    parameter int LVLW  = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [7:0]      din,
    input  logic            pop,
    output logic [7:0]      dout,
    output logic [LVLW-1:0] level,
    output logic            full,
    output logic            empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [LVLW-1:0] FULL_LVL = LVLW'(DEPTH);

    logic [7:0]      mem_q [DEPTH];
    logic [AW-1:0]   wr_ptr_q, rd_ptr_q;
    logic [LVLW-1:0] cnt_q;
    logic            do_push, do_pop;

    initial begin
        assert (DEPTH == 16 || DEPTH == 64);
    end

    assign full    = (cnt_q == FULL_LVL);
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[rd_ptr_q];
    assign level   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Level never exceeds capacity (R3, R4)
    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_LVL);
    // A push into a full queue without a pop leaves it full (R7)
    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
    // A pop from an empty queue without a push leaves it empty (R8)
    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/trail_timer.sv
`timescale 1ns/1ps
module trail_timer
    import sfifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TRL_W-1:0] limit,
    input  logic             push,
    input  logic             armed,
    output logic             fire
);
    trail_state_e     state_q, state_d;
    logic [TRL_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TR_IDLE: begin
                if (push || armed) begin
                    state_d = TR_COUNT;
                    cnt_d   = '0;
                end
            end
            TR_COUNT: begin
                if (push) begin
                    cnt_d = '0;
                end else if (!armed) begin
                    state_d = TR_IDLE;
                end else if (cnt_q >= limit) begin
                    state_d = TR_FIRED;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            TR_FIRED: begin
                if (push) begin
                    state_d = TR_COUNT;
                    cnt_d   = '0;
                end else if (!armed) begin
                    state_d = TR_IDLE;
                end
            end
            default: state_d = TR_IDLE;
        endcase
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            TR_COUNT: fire = !push && armed && (cnt_q >= limit);
            default:  fire = 1'b0;
        endcase
    end

    // The event is a single-cycle pulse per batch (R11)
    assert_fire_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    // A received byte always leads back to counting (R13)
    assert_push_restart_R13: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (state_q == TR_COUNT) && (cnt_q == '0));
endmodule

// File: rtl/serial_fifo_irq.sv
`timescale 1ns/1ps
module serial_fifo_irq
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_take,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data
);
    localparam int LVLW = $clog2(DEPTH) + 1;

    reg_idx_e addr_e;
    assign addr_e = reg_idx_e'(reg_addr);

    logic                 rx_en_q, tx_en_q;
    logic [LVL_FIELD-1:0] rx_trig_q, tx_trig_q;
    logic [NUM_EV-1:0]    ien_q, ist_q, ev_set, ev_clr;
    logic [TRL_W-1:0]     trl_q;

    logic wr_ctrl, wr_ien, wr_ist, wr_txd, wr_trl, rd_rxd;
    assign wr_ctrl = reg_wr && (addr_e == REG_CTRL);
    assign wr_ien  = reg_wr && (addr_e == REG_IEN);
    assign wr_ist  = reg_wr && (addr_e == REG_IST);
    assign wr_txd  = reg_wr && (addr_e == REG_TXD);
    assign wr_trl  = reg_wr && (addr_e == REG_TRL);
    assign rd_rxd  = reg_rd && (addr_e == REG_RXD);

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[31:23], reg_wdata[15:11], reg_wdata[3:2]};

    // Transmit queue
    logic [LVLW-1:0] tx_lvl;
    logic            tx_full, tx_empty, tx_push, tx_pop;
    logic [7:0]      tx_head;
    assign tx_push = wr_txd && tx_en_q;
    assign tx_pop  = tx_take && tx_en_q;

    byte_fifo #(.DEPTH(DEPTH), .LVLW(LVLW)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .din(reg_wdata[7:0]),
        .pop(tx_pop), .dout(tx_head),
        .level(tx_lvl), .full(tx_full), .empty(tx_empty)
    );

    // Receive queue
    logic [LVLW-1:0] rx_lvl;
    logic            rx_full, rx_empty, rx_push, rx_acc;
    logic [7:0]      rx_head;
    assign rx_push = rx_valid && rx_en_q;
    assign rx_acc  = rx_push && !rx_full;

    byte_fifo #(.DEPTH(DEPTH), .LVLW(LVLW)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(rx_data),
        .pop(rd_rxd), .dout(rx_head),
        .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    logic [LVL_FIELD-1:0] tx_lvl7, rx_lvl7;
    assign tx_lvl7 = LVL_FIELD'(tx_lvl);
    assign rx_lvl7 = LVL_FIELD'(rx_lvl);

    // Trailing timer
    logic trail_armed, trail_fire;
    assign trail_armed = !rx_empty && (rx_lvl7 < rx_trig_q);

    trail_timer u_trail (
        .clk(clk), .rst_n(rst_n),
        .limit(trl_q), .push(rx_acc),
        .armed(trail_armed), .fire(trail_fire)
    );

    // Event collection
    logic tx_ovr_ev;
    assign tx_ovr_ev = tx_push && tx_full;

    always_comb begin
        ev_set            = '0;
        ev_set[EV_TX_AE]  = tx_en_q && (tx_lvl7 <= tx_trig_q);
        ev_set[EV_RX_AF]  = rx_en_q && !rx_empty && (rx_lvl7 >= rx_trig_q);
        ev_set[EV_TX_UND] = tx_pop && tx_empty;
        ev_set[EV_TX_OVR] = tx_ovr_ev;
        ev_set[EV_RX_UND] = rd_rxd && rx_empty;
        ev_set[EV_RX_OVR] = rx_push && rx_full;
        ev_set[EV_TRAIL]  = trail_fire;
        ev_clr            = wr_ist ? reg_wdata[NUM_EV-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_en_q   <= 1'b0;
            tx_en_q   <= 1'b0;
            rx_trig_q <= '0;
            tx_trig_q <= '0;
            ien_q     <= '0;
            ist_q     <= '0;
            trl_q     <= TRL_RESET;
        end else begin
            if (wr_ctrl) begin
                rx_en_q   <= reg_wdata[0];
                tx_en_q   <= reg_wdata[1];
                rx_trig_q <= reg_wdata[10:4];
                tx_trig_q <= reg_wdata[22:16];
            end
            if (wr_ien) ien_q <= reg_wdata[NUM_EV-1:0];
            if (wr_trl) trl_q <= reg_wdata[TRL_W-1:0];
            ist_q <= (ist_q & ~ev_clr) | ev_set;
        end
    end

    assign irq      = |(ist_q & ien_q);
    assign tx_valid = tx_en_q && !tx_empty;
    assign tx_data  = tx_head;

    always_comb begin
        reg_rdata = '0;
        unique case (addr_e)
            REG_CTRL: reg_rdata = {9'd0, tx_trig_q, 5'd0, rx_trig_q, 2'd0, tx_en_q, rx_en_q};
            REG_STAT: reg_rdata = {7'd0, rx_empty, rx_full, rx_lvl7,
                                   7'd0, tx_empty, tx_full, tx_lvl7};
            REG_IEN:  reg_rdata = {25'd0, ien_q};
            REG_IST:  reg_rdata = {25'd0, ist_q};
            REG_RXD:  reg_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
            REG_TRL:  reg_rdata = {28'd0, trl_q};
            default:  reg_rdata = '0;
        endcase
    end

    // An empty receive read returns zero (R8)
    assert_rx_under_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && rx_empty) |-> (reg_rdata == 32'd0));
    // Trailing event never fires on an empty receive queue (R13)
    assert_trail_nonempty_R13: assert property (@(posedge clk) disable iff (!rst_n)
        trail_fire |-> !rx_empty);
    // A clear without a simultaneous overrun drops the bit (R9)
    assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ist && reg_wdata[EV_TX_OVR] && !tx_ovr_ev) |=> !ist_q[EV_TX_OVR]);
    // Disabled transmit side presents nothing (R12)
    assert_tx_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_q |-> !tx_valid);
endmodule

// File: tb/serial_fifo_irq_tb.sv
`timescale 1ns/1ps
module serial_fifo_irq_tb;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd1;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, tx_valid, tx_take = 1'b0, rx_valid = 1'b0;
    logic [7:0]  tx_data, rx_data = '0;

    int nchk = 0, nerr = 0;

    always #5 clk = ~clk;

    serial_fifo_irq #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_take(tx_take),
        .rx_valid(rx_valid), .rx_data(rx_data)
    );

    // Behavioural reference model
    logic [7:0]  txq[$], rxq[$];
    logic [31:0] m_ctrl;
    logic [6:0]  m_ien, m_ist;
    logic [3:0]  m_trl;
    int          m_phase, m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_ctrl = 0; m_ien = 0; m_ist = 0; m_trl = 4'hF;
            m_phase = 0; m_cnt = 0;
        end else begin
            automatic bit rxen = m_ctrl[0], txen = m_ctrl[1];
            automatic int rtrig = m_ctrl[10:4], ttrig = m_ctrl[22:16];
            automatic int txl = txq.size(), rxl = rxq.size();
            automatic logic [6:0] set = 0, clr = 0;
            automatic bit acc = 0, cond;
            cond = (rxl != 0) && (rxl < rtrig);
            if (txen && txl <= ttrig) set[0] = 1;
            if (rxen && rxl > 0 && rxl >= rtrig) set[1] = 1;
            if (txen && tx_take) begin
                if (txl == 0) set[2] = 1; else void'(txq.pop_front());
            end
            if (txen && reg_wr && reg_addr == 3'd4) begin
                if (txl == DEPTH) set[3] = 1; else txq.push_back(reg_wdata[7:0]);
            end
            if (reg_rd && reg_addr == 3'd5) begin
                if (rxl == 0) set[4] = 1; else void'(rxq.pop_front());
            end
            if (rxen && rx_valid) begin
                if (rxl == DEPTH) set[5] = 1;
                else begin rxq.push_back(rx_data); acc = 1; end
            end
            case (m_phase)
                0: if (acc || cond) begin m_phase = 1; m_cnt = 0; end
                1: if (acc) m_cnt = 0;
                   else if (!cond) m_phase = 0;
                   else if (m_cnt >= m_trl) begin m_phase = 2; set[6] = 1; end
                   else m_cnt++;
                default: if (acc) begin m_phase = 1; m_cnt = 0; end
                         else if (!cond) m_phase = 0;
            endcase
            if (reg_wr && reg_addr == 3'd3) clr = reg_wdata[6:0];
            m_ist = (m_ist & ~clr) | set;
            if (reg_wr && reg_addr == 3'd0) m_ctrl = reg_wdata & 32'h007F07F3;
            if (reg_wr && reg_addr == 3'd2) m_ien = reg_wdata[6:0];
            if (reg_wr && reg_addr == 3'd6) m_trl = reg_wdata[3:0];
        end
    end

    function automatic logic [31:0] m_status();
        automatic int t = txq.size(), r = rxq.size();
        return {7'd0, r == 0, r == DEPTH, 7'(r), 7'd0, t == 0, t == DEPTH, 7'(t)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        if (rst_n) begin
            chk("R10 irq", 32'(irq), 32'(|(m_ist & m_ien)));
            chk("R3 tx_valid", 32'(tx_valid), 32'(m_ctrl[1] && txq.size() > 0));
            if (m_ctrl[1] && txq.size() > 0) chk("R3 tx_data", 32'(tx_data), 32'(txq[0]));
            if (reg_addr == 3'd1 && !reg_wr && !reg_rd) chk("R2 status", reg_rdata, m_status());
        end
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata; reg_addr = 3'd1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; reg_addr = 3'd1; reg_wdata = '0;
    endtask

    task automatic rd_rx(output logic [31:0] v);
        reg_addr = 3'd5; reg_rd = 1'b1; #1;
        v = reg_rdata;
        chk("R4 rx read", v, rxq.size() > 0 ? 32'(rxq[0]) : 32'd0);
        tick();
        reg_rd = 1'b0; reg_addr = 3'd1;
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b; tick(); rx_valid = 1'b0;
    endtask

    task automatic take_tx();
        tx_take = 1'b1; tick(); tx_take = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        tick();
        // R1 reset state
        peek(3'd1, v); chk("R1 status", v, 32'h01000100);
        peek(3'd3, v); chk("R1 int status", v, 0);
        peek(3'd6, v); chk("R1 trailing limit", v, 32'hF);
        peek(3'd0, v); chk("R1 control", v, 0);
        peek(3'd2, v); chk("R1 int enable", v, 0);

        // enable both, RX trigger 4, TX trigger 2
        wr(3'd0, 32'h00020043);
        tick();
        peek(3'd3, v); chk("R5 almost-empty at level 0", v, 32'h1);
        peek(3'd0, v); chk("R3 control readback", v, 32'h00020043);
        wr(3'd6, 32'd3);

        wr(3'd4, 32'hA1); wr(3'd4, 32'hA2); wr(3'd4, 32'hA3);
        wr(3'd3, 32'h1);
        peek(3'd3, v); chk("R5 no almost-empty above trigger", v, 0);
        take_tx();
        tick();
        peek(3'd3, v); chk("R5 almost-empty at trigger", v & 1, 1);

        // fill past full
        for (int i = 0; i < 16; i++) wr(3'd4, 32'h10 + i);
        peek(3'd1, v); chk("R7 tx full status", v, 32'h01000090);
        peek(3'd3, v); chk("R7 tx overrun bit", (v >> 3) & 1, 1);
        for (int i = 0; i < 15; i++) take_tx();
        chk("R7 overrun byte discarded", 32'(tx_data), 32'h1D);
        take_tx();
        peek(3'd3, v); chk("R7 no underrun yet", (v >> 2) & 1, 0);
        take_tx();
        peek(3'd3, v); chk("R7 tx underrun bit", (v >> 2) & 1, 1);

        // R9 write-one-to-clear
        wr(3'd3, 32'h08);
        peek(3'd3, v); chk("R9 clear only bit 3", v & 32'hC, 32'h4);
        wr(3'd3, 32'h04);
        peek(3'd3, v); chk("R9 clear bit 2", v & 32'hC, 0);
        wr(3'd3, 32'h01);
        peek(3'd3, v); chk("R9 same-cycle event wins", v & 1, 1);

        // R11 trailing timer with limit 3
        push_rx(8'hB0);
        repeat (3) tick();
        peek(3'd3, v); chk("R11 not yet fired", (v >> 6) & 1, 0);
        tick();
        peek(3'd3, v); chk("R11 fired after limit+1 edges", (v >> 6) & 1, 1);
        wr(3'd3, 32'h40);
        push_rx(8'hB1);
        repeat (2) tick();
        push_rx(8'hB2);
        repeat (3) tick();
        peek(3'd3, v); chk("R13 push restarts count", (v >> 6) & 1, 0);
        tick();
        peek(3'd3, v); chk("R11 fired after restart", (v >> 6) & 1, 1);

        // R6 almost-full at trigger, no trailing there
        push_rx(8'hB3);
        tick();
        peek(3'd3, v); chk("R6 almost-full at trigger", (v >> 1) & 1, 1);
        wr(3'd3, 32'h40);
        repeat (6) tick();
        peek(3'd3, v); chk("R13 no trailing at trigger", (v >> 6) & 1, 0);

        rd_rx(v); chk("R4 order byte 0", v, 32'hB0);
        wr(3'd3, 32'h02);
        peek(3'd3, v); chk("R6 no almost-full below trigger", (v >> 1) & 1, 0);
        rd_rx(v); chk("R4 order byte 1", v, 32'hB1);
        rd_rx(v); chk("R4 order byte 2", v, 32'hB2);
        rd_rx(v); chk("R4 order byte 3", v, 32'hB3);
        rd_rx(v); chk("R8 empty read returns zero", v, 0);
        peek(3'd3, v); chk("R8 rx underrun bit", (v >> 4) & 1, 1);

        for (int i = 0; i < 17; i++) push_rx(8'h40 + 8'(i));
        peek(3'd1, v); chk("R8 rx full status", v, 32'h00900100);
        peek(3'd3, v); chk("R8 rx overrun bit", (v >> 5) & 1, 1);
        for (int i = 0; i < 16; i++) rd_rx(v);
        chk("R8 overrun byte discarded", v, 32'h4F);

        // R12 disabled directions
        wr(3'd0, 32'h00020040);
        wr(3'd3, 32'h7F);
        wr(3'd4, 32'h77);
        push_rx(8'h55);
        take_tx();
        peek(3'd1, v); chk("R12 queues untouched", v, 32'h01000100);
        peek(3'd3, v); chk("R12 no events when disabled", v, 0);

        // R10 interrupt gating
        wr(3'd0, 32'h00020043);
        wr(3'd2, 32'h01);
        tick();
        chk("R10 irq with enabled bit", 32'(irq), 1);
        wr(3'd2, 32'h02);
        tick();
        chk("R10 irq masked", 32'(irq), 0);
        peek(3'd2, v); chk("R10 enable readback", v, 32'h2);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule